// File: doc/BRIEF.md
# Hinted Jump Predictor with Return-Address Stack

This block sits beside the fetch unit and predicts where a privileged jump instruction will go. When a valid 32-bit instruction word carrying the privileged-jump opcode arrives with its fetch PC, the block reads a 2-bit hint. The hint picks the predicted target and the action on a small circular return-address stack. The predicted target is either a PC-relative longword displacement or the value popped from the stack. The prediction appears one cycle later.

When the real target is later computed from the source register, the block compares it with the stored prediction. On a mismatch it issues a one-cycle redirect and a kill of younger instructions. Bit 0 of the resolved value becomes the new privileged-mode flag. A stall bit in the instruction forces a mispredict whatever the comparison gives. The same bit freezes fetch until the instruction retires or aborts. While fetch is frozen, new instructions are not accepted.

Top module: `hjmp_predictor`

## Requirements
- R1: An instruction is accepted only when `inst_valid` is high, `inst_word[31:26]` equals 6'h1E and `fetch_stall` is low. Any other word gives no prediction and leaves the return stack unchanged.
- R2: Hint `inst_word[15:14]` = 2'b00 (jump) predicts `fetch_pc + 4*sext(inst_word[12:0])` and leaves the stack untouched. `pred_valid` and `pred_target` appear the cycle after acceptance.
- R3: Hint 2'b01 (call) predicts the same displacement target and pushes `fetch_pc + 4` onto the stack.
- R4: Hint 2'b10 (return) pops the stack and predicts the popped value.
- R5: Hint 2'b11 (coroutine) pops the stack for the predicted target and, in the same cycle, pushes `fetch_pc + 4`.
- R6: The stack holds 8 entries and is circular. A push onto a full stack overwrites the oldest entry, so 9 pushes followed by pops return the last 8 in reverse order and then empty.
- R7: A pop on an empty stack predicts zero and leaves the pointer unchanged.
- R8: A `resolve_valid` pulse for an outstanding instruction compares `resolve_target` with bit 0 cleared against the prediction. On a mismatch, the next cycle gives a one-cycle `redirect` with that cleared address and `kill_younger`. A match gives no redirect. The stack is never repaired, and a resolve with nothing outstanding is ignored.
- R9: `priv_mode` takes bit 0 of `resolve_target` the cycle after an accepted resolve.
- R10: When `inst_word[13]` (stall) is set, the cycle after acceptance shows `kill_younger` and `fetch_stall` high. The resolve then always redirects, even on a matching target.
- R11: `fetch_stall` stays high until a `retire` or `abort` pulse and falls the cycle after it. While it is high, instruction words are ignored.
- R12: Reset clears the stack, outstanding state, stall, redirect, kill, `pred_valid` and `priv_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Instruction word valid this cycle |
| inst_word | input | 32 | Fetched instruction word |
| fetch_pc | input | AW | Address of the instruction |
| resolve_valid | input | 1 | Register target of outstanding instruction is known |
| resolve_target | input | AW | Register value; bit 0 is the new mode flag |
| retire | input | 1 | Outstanding instruction retired |
| abort | input | 1 | Outstanding instruction aborted |
| pred_valid | output | 1 | Prediction produced this cycle |
| pred_target | output | AW | Predicted target address |
| redirect | output | 1 | Fetch must restart at redirect_target |
| redirect_target | output | AW | Resolved target with bit 0 cleared |
| kill_younger | output | 1 | Discard instructions fetched after the jump |
| fetch_stall | output | 1 | Hold fetch |
| priv_mode | output | 1 | Current privileged-mode flag |

## Verification
A corrupted stack pointer or entry count shows up at the first return-type prediction after the damage. It appears as a wrong `pred_target` one cycle after that return is accepted. This is why the tests chain pushes and pops and compare every popped address. A stuck outstanding flag or stall flag shows up at the next resolve as a missing or extra `redirect`, or as `fetch_stall` failing to fall the cycle after retire or abort. A stall flag that never clears also blocks every later prediction.

// File: rtl/hjmp_pkg.sv
package hjmp_pkg;

  localparam logic [5:0] HJ_OPCODE = 6'h1E;

  typedef enum logic [1:0] {
    HINT_JUMP = 2'b00,
    HINT_CALL = 2'b01,
    HINT_RET  = 2'b10,
    HINT_COR  = 2'b11
  } hint_e;

  typedef struct packed {
    logic        hit;
    hint_e       hint;
    logic        stall;
    logic [12:0] disp;
  } dec_t;

endpackage

// File: rtl/hjmp_decode.sv
module hjmp_decode
  import hjmp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [31:0]   inst_word,
  input  logic [AW-1:0] pc,
  output dec_t          dec,
  output logic [AW-1:0] rel_target,
  output logic [AW-1:0] link_addr
);

  logic [AW-1:0] disp_bytes;
  logic          unused_regs;

  assign dec.hit   = (inst_word[31:26] == HJ_OPCODE);
  assign dec.hint  = hint_e'(inst_word[15:14]);
  assign dec.stall = inst_word[13];
  assign dec.disp  = inst_word[12:0];

  // register fields are resolved elsewhere
  assign unused_regs = ^inst_word[25:16];

  // longword displacement, sign-extended to byte offset
  assign disp_bytes = {{(AW-15){inst_word[12]}}, inst_word[12:0], 2'b00};
  assign rel_target = pc + disp_bytes;
  assign link_addr  = pc + AW'(4);

endmodule

// File: rtl/hjmp_ret_stack.sv
module hjmp_ret_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] sp;
  logic [CW-1:0] count;
  logic [PW-1:0] sp_inc, sp_dec, wr_addr;
  logic          nonempty, do_pop;

  assign nonempty = (count != '0);
  assign do_pop   = pop && nonempty;
  assign sp_inc   = (sp == PW'(DEPTH - 1)) ? '0 : sp + PW'(1);
  assign sp_dec   = (sp == '0) ? PW'(DEPTH - 1) : sp - PW'(1);
  assign wr_addr  = do_pop ? sp_dec : sp;
  assign top_data = nonempty ? mem[sp_dec] : '0;

  always_ff @(posedge clk) begin
    if (push) mem[wr_addr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp    <= '0;
      count <= '0;
    end else begin
      unique case ({push, do_pop})
        2'b10: begin
          sp <= sp_inc;
          if (count != CW'(DEPTH)) count <= count + CW'(1);
        end
        2'b01: begin
          sp    <= sp_dec;
          count <= count - CW'(1);
        end
        default: ;
      endcase
    end
  end

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R7
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count == '0) |=> $stable(sp));

endmodule

// File: rtl/hjmp_resolve.sv
module hjmp_resolve #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          acc_stall,
  input  logic [AW-1:0] acc_pred,
  input  logic          resolve_valid,
  input  logic [AW-1:0] resolve_target,
  input  logic          retire,
  input  logic          abort,
  output logic          redirect,
  output logic [AW-1:0] redirect_target,
  output logic          kill_younger,
  output logic          fetch_stall,
  output logic          priv_mode
);

  logic          pend_valid, pend_stall;
  logic [AW-1:0] pend_pred;
  logic [AW-1:0] clean_target;
  logic          res_fire, mispredict;

  assign clean_target = {resolve_target[AW-1:1], 1'b0};
  assign res_fire     = resolve_valid && pend_valid;
  assign mispredict   = res_fire && (pend_stall || clean_target != pend_pred);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid      <= 1'b0;
      pend_stall      <= 1'b0;
      pend_pred       <= '0;
      redirect        <= 1'b0;
      redirect_target <= '0;
      kill_younger    <= 1'b0;
      fetch_stall     <= 1'b0;
      priv_mode       <= 1'b0;
    end else begin
      redirect     <= mispredict;
      kill_younger <= mispredict || (accept && acc_stall);
      if (mispredict) redirect_target <= clean_target;
      if (res_fire)   priv_mode       <= resolve_target[0];

      if (accept && acc_stall)   fetch_stall <= 1'b1;
      else if (retire || abort)  fetch_stall <= 1'b0;

      if (accept) begin
        pend_valid <= 1'b1;
        pend_stall <= acc_stall;
        pend_pred  <= acc_pred;
      end else if (res_fire) begin
        pend_valid <= 1'b0;
      end
    end
  end

  // R8
  redirect_cause_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> $past(resolve_valid));

  // R8
  redirect_kill_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> kill_younger);

  // R11
  stall_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fetch_stall) |-> $past(retire || abort));

endmodule

// File: rtl/hjmp_predictor.sv
module hjmp_predictor
  import hjmp_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inst_valid,
  input  logic [31:0]   inst_word,
  input  logic [AW-1:0] fetch_pc,
  input  logic          resolve_valid,
  input  logic [AW-1:0] resolve_target,
  input  logic          retire,
  input  logic          abort,
  output logic          pred_valid,
  output logic [AW-1:0] pred_target,
  output logic          redirect,
  output logic [AW-1:0] redirect_target,
  output logic          kill_younger,
  output logic          fetch_stall,
  output logic          priv_mode
);

  dec_t          dec;
  logic [AW-1:0] rel_target, link_addr, stack_top, pred_next;
  logic          accept, uses_stack, do_push, do_pop;

  hjmp_decode #(.AW(AW)) u_dec (
    .inst_word  (inst_word),
    .pc         (fetch_pc),
    .dec        (dec),
    .rel_target (rel_target),
    .link_addr  (link_addr)
  );

  assign accept     = inst_valid && dec.hit && !fetch_stall;
  assign uses_stack = (dec.hint == HINT_RET) || (dec.hint == HINT_COR);
  assign do_push    = accept && ((dec.hint == HINT_CALL) || (dec.hint == HINT_COR));
  assign do_pop     = accept && uses_stack;
  assign pred_next  = uses_stack ? stack_top : rel_target;

  hjmp_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_ras (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .pop       (do_pop),
    .push_data (link_addr),
    .top_data  (stack_top)
  );

  hjmp_resolve #(.AW(AW)) u_res (
    .clk             (clk),
    .rst             (rst),
    .accept          (accept),
    .acc_stall       (dec.stall),
    .acc_pred        (pred_next),
    .resolve_valid   (resolve_valid),
    .resolve_target  (resolve_target),
    .retire          (retire),
    .abort           (abort),
    .redirect        (redirect),
    .redirect_target (redirect_target),
    .kill_younger    (kill_younger),
    .fetch_stall     (fetch_stall),
    .priv_mode       (priv_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_target <= '0;
    end else begin
      pred_valid <= accept;
      if (accept) pred_target <= pred_next;
    end
  end

  // R1
  pred_source_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(inst_valid));

  // R11
  frozen_no_pred_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fetch_stall) |-> !pred_valid);

endmodule

// File: tb/hjmp_predictor_test.sv
module hjmp_predictor_test;

  localparam int CLK_P = 10;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inst_valid = 1'b0;
  logic [31:0]   inst_word = '0;
  logic [AW-1:0] fetch_pc = '0;
  logic          resolve_valid = 1'b0;
  logic [AW-1:0] resolve_target = '0;
  logic          retire = 1'b0;
  logic          abort = 1'b0;
  logic          pred_valid, redirect, kill_younger, fetch_stall, priv_mode;
  logic [AW-1:0] pred_target, redirect_target;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  hjmp_predictor #(.AW(AW), .DEPTH(8)) uut (
    .clk(clk), .rst(rst), .inst_valid(inst_valid), .inst_word(inst_word),
    .fetch_pc(fetch_pc), .resolve_valid(resolve_valid),
    .resolve_target(resolve_target), .retire(retire), .abort(abort),
    .pred_valid(pred_valid), .pred_target(pred_target), .redirect(redirect),
    .redirect_target(redirect_target), .kill_younger(kill_younger),
    .fetch_stall(fetch_stall), .priv_mode(priv_mode)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [1:0] hint,
                                     input logic st, input logic [12:0] d);
    return {op, 5'd31, 5'd3, hint, st, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] pc);
    @(negedge clk); inst_valid = 1'b1; inst_word = w; fetch_pc = pc;
    @(negedge clk); inst_valid = 1'b0;
  endtask

  task automatic resolve(input logic [31:0] t);
    @(negedge clk); resolve_valid = 1'b1; resolve_target = t;
    @(negedge clk); resolve_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 pred_valid", 32'(pred_valid), 0);
    chk("R12 redirect", 32'(redirect), 0);
    chk("R12 kill", 32'(kill_younger), 0);
    chk("R12 stall", 32'(fetch_stall), 0);
    chk("R12 priv", 32'(priv_mode), 0);
  endtask

  task automatic t_jump();
    do_reset();
    issue(mk(6'h1E, 2'b00, 1'b0, 13'd5), 32'h1000);
    chk("R2 valid", 32'(pred_valid), 1);
    chk("R2 target", pred_target, 32'h1014);
    issue(mk(6'h1E, 2'b00, 1'b0, -13'sd3), 32'h2000);
    chk("R2 negative disp", pred_target, 32'h1FF4);
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h3000);
    chk("R2 no push / R7 empty pop", pred_target, 32'h0);
  endtask

  task automatic t_call_ret();
    do_reset();
    issue(mk(6'h1E, 2'b01, 1'b0, 13'd8), 32'h100);
    chk("R3 call target", pred_target, 32'h120);
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h500);
    chk("R4 return pops link", pred_target, 32'h104);
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h600);
    chk("R7 empty pop zero", pred_target, 32'h0);
    issue(mk(6'h1E, 2'b01, 1'b0, 13'd1), 32'h200);
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h700);
    chk("R7 pointer kept", pred_target, 32'h204);
  endtask

  task automatic t_coroutine();
    do_reset();
    issue(mk(6'h1E, 2'b01, 1'b0, 13'd4), 32'h300);
    issue(mk(6'h1E, 2'b11, 1'b0, 13'd0), 32'h800);
    chk("R5 coroutine target", pred_target, 32'h304);
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h900);
    chk("R5 coroutine pushed", pred_target, 32'h804);
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'hA00);
    chk("R5 depth unchanged", pred_target, 32'h0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 9; i++)
      issue(mk(6'h1E, 2'b01, 1'b0, 13'd2), 32'h1000 + 32'(i) * 32'h10);
    for (int i = 8; i >= 1; i--) begin
      issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h9000);
      chk("R6 wrap order", pred_target, 32'h1004 + 32'(i) * 32'h10);
    end
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h9000);
    chk("R6 oldest lost", pred_target, 32'h0);
  endtask

  task automatic t_bad_opcode();
    do_reset();
    issue(mk(6'h1D, 2'b01, 1'b0, 13'd8), 32'h400);
    chk("R1 no prediction", 32'(pred_valid), 0);
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h500);
    chk("R1 no push", pred_target, 32'h0);
  endtask

  task automatic t_resolve();
    do_reset();
    resolve(32'h3000);
    chk("R8 idle resolve ignored", 32'(redirect), 0);
    issue(mk(6'h1E, 2'b00, 1'b0, 13'd4), 32'h1000);
    resolve(32'h1010);
    chk("R8 match no redirect", 32'(redirect), 0);
    chk("R9 priv 0", 32'(priv_mode), 0);
    issue(mk(6'h1E, 2'b00, 1'b0, 13'd4), 32'h1000);
    resolve(32'h1011);
    chk("R8 bit0 cleared match", 32'(redirect), 0);
    chk("R9 priv 1", 32'(priv_mode), 1);
    issue(mk(6'h1E, 2'b00, 1'b0, 13'd4), 32'h1000);
    resolve(32'h2000);
    chk("R8 mismatch redirect", 32'(redirect), 1);
    chk("R8 redirect target", redirect_target, 32'h2000);
    chk("R8 kill on redirect", 32'(kill_younger), 1);
    chk("R9 priv back to 0", 32'(priv_mode), 0);
    @(negedge clk);
    chk("R8 one-cycle redirect", 32'(redirect), 0);
    issue(mk(6'h1E, 2'b01, 1'b0, 13'd0), 32'h100);
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h200);
    resolve(32'h901);
    chk("R8 return mispredict", redirect_target, 32'h900);
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h300);
    chk("R8 no stack repair", pred_target, 32'h0);
  endtask

  task automatic t_stall();
    do_reset();
    issue(mk(6'h1E, 2'b00, 1'b1, 13'd2), 32'h100);
    chk("R10 stall target", pred_target, 32'h108);
    chk("R10 kill", 32'(kill_younger), 1);
    chk("R10 fetch_stall", 32'(fetch_stall), 1);
    issue(mk(6'h1E, 2'b01, 1'b0, 13'd0), 32'h400);
    chk("R11 ignored while stalled", 32'(pred_valid), 0);
    chk("R10 kill one cycle", 32'(kill_younger), 0);
    resolve(32'h108);
    chk("R10 forced redirect", 32'(redirect), 1);
    chk("R10 forced target", redirect_target, 32'h108);
    chk("R11 still stalled", 32'(fetch_stall), 1);
    @(negedge clk); retire = 1'b1;
    @(negedge clk); retire = 1'b0;
    chk("R11 retire releases", 32'(fetch_stall), 0);
    issue(mk(6'h1E, 2'b10, 1'b0, 13'd0), 32'h500);
    chk("R11 ignored call not pushed", pred_target, 32'h0);
    issue(mk(6'h1E, 2'b01, 1'b1, 13'd0), 32'h100);
    chk("R10 stall on call", 32'(fetch_stall), 1);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R11 abort releases", 32'(fetch_stall), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_jump();
    t_call_ret();
    t_coroutine();
    t_overflow();
    t_bad_opcode();
    t_resolve();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule